// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM. A host pulses a request together with a 6-bit word address. The block then asserts chip select and clocks out an 11-bit read command on the data-in pin, one bit per serial clock pulse. It then clocks 16 more pulses and samples the EEPROM's data-out pin while the clock is high. When the word has been assembled, the block drops chip select, presents the word and pulses a done strobe for one cycle.

The serial clock is derived from the system clock. A parameter sets the number of system cycles in each clock phase, so slow parts get their minimum phase time of 2 microseconds; at 250 MHz that is 500 cycles. Board wiring may invert any of the four serial signals. A 4-bit polarity input flips each signal independently, so the internal sequencer always works with active-high levels.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset and while idle, chip select, serial clock and data-in are at logical low, so each pin equals its polarity bit. The busy and done outputs are low and the read data is zero.
- R2: The command is 11 bits long and is sent MSB first. Its value is the word address OR'd with 384, so the bits are 0,0,1,1,0 followed by address bits 5 down to 0.
- R3: Each command bit is set up on data-in while the clock is low. The clock then rises and falls, and data-in does not change while the clock is high.
- R4: During the 16 data clock pulses, data-in is held at logical low.
- R5: Sixteen data-out bits are sampled MSB first while the clock is high. The first bit sampled becomes bit 15 of the read data.
- R6: Chip select is asserted before the first clock rise, and the clock only pulses while chip select is asserted. Each read has exactly 27 clock pulses, and chip select is released after the 16th data bit.
- R7: Every high and every low phase of the serial clock within a transaction lasts at least HALF_DIV system cycles.
- R8: The polarity bits apply per pin: bit 0 inverts data-in, bit 1 inverts data-out, bit 2 inverts clock and bit 3 inverts chip select. A set bit XORs that pin.
- R9: Busy is high from the cycle after an accepted request until done. A request that arrives while busy is ignored and does not change the command, the result or the number of transactions.
- R10: Done is high for exactly one cycle. The read data changes only in that cycle and then holds until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req_i | input | 1 | One-cycle read request |
| rd_addr_i | input | 6 | Word address, sampled with the request |
| pol_i | input | 4 | Per-pin inversion: 0 data-in, 1 data-out, 2 clock, 3 select; hold constant while busy |
| rd_data_o | output | 16 | Last word read |
| rd_done_o | output | 1 | One-cycle strobe when rd_data_o is updated |
| busy_o | output | 1 | A transaction is in progress |
| ee_cs_o | output | 1 | Serial chip select pin |
| ee_sk_o | output | 1 | Serial clock pin |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach is a second request that lands deep inside a running transaction. It must leave the shifted command, the sampled bits and the pulse count untouched. The bench raises a request with a different address part-way through the command and data phases and then checks three things: the behavioural EEPROM saw only the first command, the result matches the first address, and no second chip-select window opens. The random polarity settings also make the bench model decode every pin through its own inversion. This catches a polarity bit applied to the wrong pin.

// File: rtl/eer_pkg.sv
package eer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_CLO  = 3'd2,
    ST_CHI  = 3'd3,
    ST_DLO  = 3'd4,
    ST_DHI  = 3'd5,
    ST_FIN  = 3'd6
  } eer_state_e;

  // start bit followed by the two-bit read opcode
  localparam logic [2:0] EER_RD_OP = 3'b110;
  localparam int unsigned EER_PAD_W = 2;

endpackage

// File: rtl/eer_half_tick.sv
module eer_half_tick #(
  parameter int unsigned HALF_DIV = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/eer_pin_pol.sv
module eer_pin_pol #(
  parameter int unsigned N = 1
) (
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    assign lvl_o[g] = lvl_i[g] ^ inv_i[g];
  end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eer_pkg::*;
#(
  parameter int unsigned HALF_DIV = 500,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [3:0]        pol_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_done_o,
  output logic              busy_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int unsigned CMD_W = EER_PAD_W + 3 + ADDR_W;
  localparam int unsigned MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int unsigned CNT_W = $clog2(MAXB + 1);
  localparam int unsigned RUN_W = $clog2(HALF_DIV + 2);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  eer_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_q, done_d;
  logic              cs_q, cs_d, sk_q, sk_d, di_q, di_d;
  logic              tick, do_l;

  eer_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  eer_pin_pol #(.N(3)) u_pol_out (
    .lvl_i ({cs_q, sk_q, di_q}),
    .inv_i ({pol_i[3], pol_i[2], pol_i[0]}),
    .lvl_o ({ee_cs_o, ee_sk_o, ee_di_o})
  );

  eer_pin_pol #(.N(1)) u_pol_in (
    .lvl_i (ee_do_i),
    .inv_i (pol_i[1]),
    .lvl_o (do_l)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    cmd_d   = cmd_q;
    rx_d    = rx_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (rd_req_i) begin
        state_d = ST_SEL;
        cmd_d   = {{EER_PAD_W{1'b0}}, EER_RD_OP, rd_addr_i};
        bit_d   = '0;
      end
      ST_SEL: if (tick) state_d = ST_CLO;
      ST_CLO: if (tick) state_d = ST_CHI;
      ST_CHI: if (tick) begin
        cmd_d = cmd_q << 1;
        if (bit_q == CNT_W'(CMD_W - 1)) begin
          bit_d   = '0;
          state_d = ST_DLO;
        end else begin
          bit_d   = bit_q + 1'b1;
          state_d = ST_CLO;
        end
      end
      ST_DLO: if (tick) state_d = ST_DHI;
      ST_DHI: if (tick) begin
        rx_d = {rx_q[DATA_W-2:0], do_l};
        if (bit_q == CNT_W'(DATA_W - 1)) begin
          bit_d   = '0;
          state_d = ST_FIN;
        end else begin
          bit_d   = bit_q + 1'b1;
          state_d = ST_DLO;
        end
      end
      ST_FIN: if (tick) begin
        state_d = ST_IDLE;
        rdata_d = rx_q;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    cs_d = (state_q != ST_IDLE) && (state_q != ST_FIN);
    sk_d = (state_q == ST_CHI) || (state_q == ST_DHI);
    di_d = ((state_q == ST_CLO) || (state_q == ST_CHI)) && cmd_q[CMD_W-1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cmd_q   <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      cmd_q   <= cmd_d;
      rx_q    <= rx_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      di_q    <= di_d;
    end
  end

  assign rd_data_o = rdata_q;
  assign rd_done_o = done_q;
  assign busy_o    = (state_q != ST_IDLE);

  // phase-length tracker for the R7 check
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)               run_q <= '0;
    else if (sk_d != sk_q)      run_q <= RUN_W'(1);
    else if (run_q != RUN_W'(HALF_DIV)) run_q <= run_q + 1'b1;
  end

  p_phase_min_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sk_d != sk_q) |-> (run_q >= RUN_W'(HALF_DIV)));

  p_di_stable_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sk_q && $past(sk_q)) |-> $stable(di_q));

  p_sk_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(sk_q) |-> (cs_q && $past(cs_q)));

  p_di_low_data_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((state_q == ST_DHI) && sk_q) |-> !di_q);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_done_o |=> !rd_done_o);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_done_o |-> $stable(rd_data_o));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && !tick) |=> busy_o);

endmodule

// File: tb/eeprom_word_reader_bench.sv
`timescale 1ns/1ps
module eeprom_word_reader_bench;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req;
  logic [5:0]  rd_addr;
  logic [3:0]  pol;
  logic [15:0] rd_data;
  logic        rd_done, busy;
  logic        ee_cs, ee_sk, ee_di;
  logic        do_l;
  logic        ee_do;

  always #2 clk = ~clk;

  assign ee_do = do_l ^ pol[1];

  eeprom_word_reader #(.HALF_DIV(HALF)) u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .pol_i(pol), .rd_data_o(rd_data), .rd_done_o(rd_done), .busy_o(busy),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do)
  );

  int total = 0, fails = 0, cyc = 0;

  function automatic logic [15:0] word_of(input logic [5:0] a);
    return {a, ~a[3:0], a ^ 6'h2A};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural EEPROM, decoding pins through the bench's own polarity
  logic cs_l, sk_l, di_l;
  assign cs_l = ee_cs ^ pol[3];
  assign sk_l = ee_sk ^ pol[2];
  assign di_l = ee_di ^ pol[0];

  logic        cs_p, sk_p, di_p;
  logic [10:0] cmd_rx;
  int cmd_n, pulses, out_idx, di_bad, di_move, short_ph, run_len, windows;

  always @(negedge clk) begin
    if (!rst_n) begin
      cs_p = 0; sk_p = 0; di_p = 0; cmd_rx = '0; cmd_n = 0; pulses = 0;
      out_idx = 16; di_bad = 0; di_move = 0; short_ph = 0; run_len = 0;
      windows = 0; do_l = 0;
    end else begin
      if (sk_l != sk_p) begin
        if (cs_l && run_len < HALF) short_ph++;
        run_len = 1;
      end else run_len++;
      if (cs_l && !cs_p) begin
        cmd_rx = '0; cmd_n = 0; pulses = 0; out_idx = 16; windows++;
      end
      if (cs_l && sk_l && !sk_p) begin
        pulses++;
        if (cmd_n < 11) begin
          cmd_rx = {cmd_rx[9:0], di_l};
          cmd_n++;
        end else begin
          if (di_l) di_bad++;
          if (out_idx > 0) begin
            do_l = word_of(cmd_rx[5:0])[out_idx-1];
            out_idx--;
          end
        end
      end
      if (cs_l && sk_l && sk_p && (di_l != di_p)) di_move++;
      cs_p = cs_l; sk_p = sk_l; di_p = di_l;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  task automatic do_read(input logic [5:0] a, input logic [3:0] p, input bit poke);
    int w0, n;
    logic [15:0] held;
    pol = p;
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_di} == {p[3], p[2], p[0]}, "R8 idle pins", {ee_cs, ee_sk, ee_di}, {p[3], p[2], p[0]});
    w0 = windows;
    rd_addr = a; rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    chk(busy === 1'b1, "R9 busy after req", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      rd_addr = a ^ 6'h15; rd_req = 1;
      @(negedge clk);
      rd_req = 0;
      repeat (60) @(negedge clk);
      rd_addr = ~a; rd_req = 1;
      @(negedge clk);
      rd_req = 0;
    end
    n = 0;
    while (!rd_done && n < 2000) begin @(negedge clk); n++; end
    chk(rd_done === 1'b1, "R10 done seen", rd_done, 1);
    chk(rd_data == word_of(a), "R5 read data", rd_data, word_of(a));
    chk(cmd_rx == (11'd384 | 11'(a)), "R2 command bits", cmd_rx, 11'd384 | 11'(a));
    chk(pulses == 27, "R6 clock pulse count", pulses, 27);
    chk(cs_l == 1'b0, "R6 select released", cs_l, 0);
    chk(windows == w0 + 1, "R9 one transaction", windows - w0, 1);
    held = rd_data;
    @(negedge clk);
    chk(rd_done == 1'b0, "R10 done one cycle", rd_done, 0);
    repeat (12) @(negedge clk);
    chk(rd_data == held, "R10 data held", rd_data, held);
    chk(busy == 1'b0 && windows == w0 + 1, "R9 no restart", windows - w0, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; rd_req = 0; rd_addr = '0; pol = 4'h0;
    repeat (5) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 reset pins", {ee_cs, ee_sk, ee_di}, 0);
    chk(busy == 0 && rd_done == 0, "R1 reset flags", {busy, rd_done}, 0);
    chk(rd_data == 16'h0, "R1 reset data", rd_data, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    do_read(6'h00, 4'h0, 0);
    do_read(6'h3F, 4'hF, 0);
    do_read(6'h2A, 4'h5, 0);
    do_read(6'h15, 4'hA, 1);
    for (int i = 0; i < 24; i++)
      do_read(6'($urandom), 4'($urandom), (i % 6) == 5);
    chk(di_bad == 0, "R4 data-in low in data phase", di_bad, 0);
    chk(di_move == 0, "R3 data-in stable while clock high", di_move, 0);
    chk(short_ph == 0, "R7 short clock phases", short_ph, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule